// File: doc/BRIEF.md
# ADC Conversion Rate Pacer

The pacer issues one-cycle conversion-start strobes for an ADC sequencer. The number of ADC clock cycles between strobes comes from three rate fields: a coarse bit worth 16 cycles, a 2-bit middle field worth 4 cycles per step, and a 2-bit fine field worth 1 cycle per step. All three are added to a fixed base of 16 cycles. While the enable input is low, the pacer does nothing. The first strobe comes out one cycle after the pacer sees enable high.

When synchronization is requested, each start is aligned to a pulse from the switching power supply. Once the period count has run out, the pacer holds and waits for the supply pulse. It issues the strobe on the cycle after that pulse. Alignment is not possible when the fine field is nonzero. In that case the pacer ignores the pulse and runs freely, and a status output reports whether alignment is actually in effect.

A mode bit chooses where input sampling begins, and a sample strobe marks that point. In the default mode, sampling happens only at conversion start. In the other mode, sampling restarts on the last cycle of each conversion, ahead of the next start.

Top module: `adc_rate_pacer`

## Requirements
- R1: While enable_i is low at a clock edge, start_o and sample_o are low in the following cycle; both are low out of reset.
- R2: When enable_i is first seen high at an edge after being low, start_o is high for exactly the next cycle.
- R3: With alignment not in effect, consecutive start_o pulses are exactly 16 + 16·rate_msb_i + 4·rate_mid_i + rate_fine_i cycles apart.
- R4: sync_active_o is high exactly when sync_en_i is 1 and rate_fine_i is 0.
- R5: With sync_active_o high, once the period has run out no start_o occurs until sync_pulse_i is high; start_o then rises in the cycle after the pulse.
- R6: With rate_fine_i nonzero, sync_pulse_i has no effect and starts stay free-running at the R3 period, even when sync_en_i is 1.
- R7: Dropping enable_i stops strobes from the next cycle and clears the count; re-enabling restarts as in R2.
- R8: With sample_at_eoc_i = 0 (sample at start), sample_o equals start_o in every cycle.
- R9: With sample_at_eoc_i = 1, sample_o is high together with the first start after enable, and then on the last cycle of each conversion, one cycle before the following free-running start.
- R10: With sample_at_eoc_i = 1 and alignment in effect, sample_o pulses once, on the last cycle of the period count, and not again while waiting for the supply pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | ADC clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Run enable |
| rate_msb_i | input | 1 | Coarse rate field (weight 16) |
| rate_mid_i | input | 2 | Middle rate field (weight 4) |
| rate_fine_i | input | 2 | Fine rate field (weight 1); nonzero blocks alignment |
| sync_en_i | input | 1 | Request alignment to supply pulse |
| sync_pulse_i | input | 1 | Pulse from switching supply |
| sample_at_eoc_i | input | 1 | 0: sample at start; 1: sample from end of conversion |
| start_o | output | 1 | Conversion-start strobe |
| sample_o | output | 1 | Sampling-begin strobe |
| sync_active_o | output | 1 | Alignment in effect |

## Verification
A corrupted period counter shows up at the ports as a start_o spacing that differs from the field sum. This is visible at the second strobe after enable, which is at most 47 cycles later. A wait state that is stuck or left too early shows up as a strobe with no supply pulse before it, or as a pulse with no strobe in the next cycle. A bad sampling selection shows up in the first conversion as a sample_o that is not aligned to start_o, or that is not one cycle ahead of it.

// File: rtl/adc_pacer_pkg.sv
package adc_pacer_pkg;
  typedef enum logic [1:0] {
    PC_IDLE  = 2'd0,
    PC_COUNT = 2'd1,
    PC_WAIT  = 2'd2
  } pacer_state_e;
endpackage

// File: rtl/pacer_period.sv
module pacer_period #(
  parameter int MSB_W  = 1,
  parameter int MID_W  = 2,
  parameter int FINE_W = 2,
  parameter int BASE   = 16,
  parameter int MSB_WT = 16,
  parameter int MID_WT = 4,
  parameter int PER_W  = 6
) (
  input  logic [MSB_W-1:0]  msb_i,
  input  logic [MID_W-1:0]  mid_i,
  input  logic [FINE_W-1:0] fine_i,
  output logic [PER_W-1:0]  period_o
);
  always_comb begin
    period_o = PER_W'(BASE)
             + PER_W'(MSB_WT) * PER_W'(msb_i)
             + PER_W'(MID_WT) * PER_W'(mid_i)
             + PER_W'(fine_i);
  end
endmodule

// File: rtl/pacer_sync_gate.sv
module pacer_sync_gate #(
  parameter int FINE_W = 2
) (
  input  logic              sync_en_i,
  input  logic [FINE_W-1:0] fine_i,
  output logic              active_o
);
  // any fine offset breaks alignment with the supply pulse
  assign active_o = sync_en_i & ~(|fine_i);
endmodule

// File: rtl/pacer_counter.sv
module pacer_counter
  import adc_pacer_pkg::*;
#(
  parameter int PER_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             sync_mode_i,
  input  logic             sync_pulse_i,
  output logic             issue_o,
  output logic             first_o,
  output logic             pre_eoc_o,
  output pacer_state_e     state_o
);
  pacer_state_e     state_q, state_d;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             last, expired;

  // >= so a shortened period mid-count still terminates
  assign last      = (cnt_q >= period_i - PER_W'(1));
  assign expired   = (state_q == PC_COUNT && last) || (state_q == PC_WAIT);
  assign first_o   = enable_i && (state_q == PC_IDLE);
  assign issue_o   = first_o || (enable_i && expired && (!sync_mode_i || sync_pulse_i));
  assign pre_eoc_o = enable_i && (state_q == PC_COUNT) && (cnt_q == period_i - PER_W'(2));
  assign state_o   = state_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!enable_i) begin
      state_d = PC_IDLE;
      cnt_d   = '0;
    end else if (issue_o) begin
      state_d = PC_COUNT;
      cnt_d   = '0;
    end else if (state_q == PC_COUNT) begin
      if (last) state_d = PC_WAIT;
      else      cnt_d   = cnt_q + PER_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PC_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/pacer_strobe.sv
module pacer_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eoc_mode_i,
  input  logic issue_i,
  input  logic first_i,
  input  logic pre_eoc_i,
  output logic start_o,
  output logic sample_o
);
  logic start_q, sample_q, sample_d;

  assign sample_d = eoc_mode_i ? (first_i | pre_eoc_i) : issue_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      start_q  <= issue_i;
      sample_q <= sample_d;
    end
  end

  assign start_o  = start_q;
  assign sample_o = sample_q;
endmodule

// File: rtl/adc_rate_pacer.sv
module adc_rate_pacer
  import adc_pacer_pkg::*;
#(
  parameter int MSB_W  = 1,
  parameter int MID_W  = 2,
  parameter int FINE_W = 2,
  parameter int BASE   = 16,
  parameter int MSB_WT = 16,
  parameter int MID_WT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [MSB_W-1:0]  rate_msb_i,
  input  logic [MID_W-1:0]  rate_mid_i,
  input  logic [FINE_W-1:0] rate_fine_i,
  input  logic              sync_en_i,
  input  logic              sync_pulse_i,
  input  logic              sample_at_eoc_i,
  output logic              start_o,
  output logic              sample_o,
  output logic              sync_active_o
);
  localparam int MAX_PER = BASE + MSB_WT * (2**MSB_W - 1)
                         + MID_WT * (2**MID_W - 1) + (2**FINE_W - 1);
  localparam int PER_W   = $clog2(MAX_PER + 1);

  logic [PER_W-1:0] period_w;
  logic             issue_w, first_w, pre_eoc_w;
  pacer_state_e     state_w;

  pacer_period #(
    .MSB_W(MSB_W), .MID_W(MID_W), .FINE_W(FINE_W),
    .BASE(BASE), .MSB_WT(MSB_WT), .MID_WT(MID_WT), .PER_W(PER_W)
  ) u_period (
    .msb_i   (rate_msb_i),
    .mid_i   (rate_mid_i),
    .fine_i  (rate_fine_i),
    .period_o(period_w)
  );

  pacer_sync_gate #(.FINE_W(FINE_W)) u_gate (
    .sync_en_i(sync_en_i),
    .fine_i   (rate_fine_i),
    .active_o (sync_active_o)
  );

  pacer_counter #(.PER_W(PER_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .period_i    (period_w),
    .sync_mode_i (sync_active_o),
    .sync_pulse_i(sync_pulse_i),
    .issue_o     (issue_w),
    .first_o     (first_w),
    .pre_eoc_o   (pre_eoc_w),
    .state_o     (state_w)
  );

  pacer_strobe u_strobe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eoc_mode_i(sample_at_eoc_i),
    .issue_i   (issue_w),
    .first_i   (first_w),
    .pre_eoc_i (pre_eoc_w),
    .start_o   (start_o),
    .sample_o  (sample_o)
  );
endmodule

// File: rtl/adc_rate_pacer_chk.sv
module adc_rate_pacer_chk
  import adc_pacer_pkg::*;
#(
  parameter int FINE_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic [FINE_W-1:0] rate_fine_i,
  input logic              sync_pulse_i,
  input logic              sample_at_eoc_i,
  input logic              start_o,
  input logic              sample_o,
  input logic              sync_active_o,
  input pacer_state_e      state_i
);
  logic en_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_seen_q <= 1'b1;
    else         en_seen_q <= enable_i;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!start_o && !sample_o));

  assert_first_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !en_seen_q) |=> start_o);

  assert_fine_blocks_sync_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_active_o |-> (rate_fine_i == '0));

  assert_wait_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && state_i == PC_WAIT && sync_active_o && !sync_pulse_i) |=> !start_o);

  assert_sample_at_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_at_eoc_i |=> (sample_o == start_o));

  assert_single_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
endmodule

bind adc_rate_pacer adc_rate_pacer_chk #(.FINE_W(FINE_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .enable_i       (enable_i),
  .rate_fine_i    (rate_fine_i),
  .sync_pulse_i   (sync_pulse_i),
  .sample_at_eoc_i(sample_at_eoc_i),
  .start_o        (start_o),
  .sample_o       (sample_o),
  .sync_active_o  (sync_active_o),
  .state_i        (state_w)
);

// File: tb/adc_rate_pacer_tb_top.sv
module adc_rate_pacer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enable_i = 1'b0;
  logic       rate_msb_i = 1'b0;
  logic [1:0] rate_mid_i = '0;
  logic [1:0] rate_fine_i = '0;
  logic       sync_en_i = 1'b0;
  logic       sync_pulse_i = 1'b0;
  logic       sample_at_eoc_i = 1'b0;
  logic       start_o, sample_o, sync_active_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk_i = ~clk_i;

  adc_rate_pacer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i),
    .rate_msb_i(rate_msb_i), .rate_mid_i(rate_mid_i), .rate_fine_i(rate_fine_i),
    .sync_en_i(sync_en_i), .sync_pulse_i(sync_pulse_i),
    .sample_at_eoc_i(sample_at_eoc_i),
    .start_o(start_o), .sample_o(sample_o), .sync_active_o(sync_active_o)
  );

  // {msb, mid[1:0], fine[1:0], sync_en}
  localparam logic [5:0] CFG [0:5] = '{
    6'b0_00_00_0, 6'b1_00_00_0, 6'b0_11_00_0,
    6'b0_00_11_0, 6'b1_11_11_1, 6'b0_10_01_1
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic to_next_start(output int n, output bit samp);
    n = 0;
    do begin
      step();
      n++;
    end while (!start_o && n < 200);
    samp = sample_o;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n, exp_p;
    bit s;
    #23;
    check(!start_o && !sample_o, "R1 reset", int'(start_o), 0);
    rst_ni = 1'b1;
    step();
    step();
    check(!start_o && !sample_o, "R1 disabled", int'(start_o), 0);

    for (int i = 0; i < 6; i++) begin
      enable_i = 1'b0;
      {rate_msb_i, rate_mid_i, rate_fine_i, sync_en_i} = CFG[i];
      exp_p = 16 + 16 * int'(rate_msb_i) + 4 * int'(rate_mid_i) + int'(rate_fine_i);
      step();
      check(sync_active_o == (sync_en_i && rate_fine_i == 0), "R4 status",
            int'(sync_active_o), int'(sync_en_i && rate_fine_i == 0));
      enable_i = 1'b1;
      sync_pulse_i = 1'b0;
      step();
      check(start_o == 1'b1, "R2 first start", int'(start_o), 1);
      for (int k = 0; k < 2; k++) begin
        to_next_start(n, s);
        check(n == exp_p, (CFG[i][0] ? "R6 free-run with fine" : "R3 period"), n, exp_p);
        check(s == 1'b1, "R8 sample with start", int'(s), 1);
      end
    end

    // R5 alignment wait
    enable_i = 1'b0;
    {rate_msb_i, rate_mid_i, rate_fine_i, sync_en_i} = 6'b0_00_00_1;
    step();
    check(sync_active_o == 1'b1, "R4 active", int'(sync_active_o), 1);
    enable_i = 1'b1;
    step();
    check(start_o == 1'b1, "R2 sync first", int'(start_o), 1);
    n = 0;
    for (int k = 0; k < 40; k++) begin
      step();
      if (start_o) n++;
    end
    check(n == 0, "R5 no start without pulse", n, 0);
    sync_pulse_i = 1'b1;
    step();
    sync_pulse_i = 1'b0;
    check(start_o == 1'b1, "R5 start after pulse", int'(start_o), 1);
    step();
    check(start_o == 1'b0, "R5 single strobe", int'(start_o), 0);

    // R6 pulse ignored with fine offset
    enable_i = 1'b0;
    {rate_msb_i, rate_mid_i, rate_fine_i, sync_en_i} = 6'b0_00_10_1;
    step();
    enable_i = 1'b1;
    step();
    sync_pulse_i = 1'b1;
    step();
    sync_pulse_i = 1'b0;
    check(start_o == 1'b0, "R6 pulse ignored", int'(start_o), 0);
    to_next_start(n, s);
    check(n == 17, "R6 free period", n + 1, 18);

    // R7 disable mid-run
    for (int k = 0; k < 5; k++) step();
    enable_i = 1'b0;
    step();
    n = 0;
    for (int k = 0; k < 30; k++) begin
      if (start_o || sample_o) n++;
      step();
    end
    check(n == 0, "R7 stopped", n, 0);
    enable_i = 1'b1;
    step();
    check(start_o == 1'b1, "R7 restart", int'(start_o), 1);

    // R9 sample at end of conversion, free-running
    enable_i = 1'b0;
    {rate_msb_i, rate_mid_i, rate_fine_i, sync_en_i} = 6'b0_00_00_0;
    sample_at_eoc_i = 1'b1;
    step();
    enable_i = 1'b1;
    step();
    check(start_o && sample_o, "R9 first sample with start", int'(sample_o), 1);
    n = 0;
    do begin
      step();
      n++;
    end while (!sample_o && n < 100);
    check(n == 15 && !start_o, "R9 sample before start", n, 15);
    step();
    check(start_o && !sample_o, "R9 start after sample", int'(start_o), 1);

    // R10 sample at end with alignment
    enable_i = 1'b0;
    sync_en_i = 1'b1;
    step();
    enable_i = 1'b1;
    step();
    n = 0;
    s = 1'b0;
    for (int k = 1; k <= 45; k++) begin
      step();
      if (sample_o) begin
        n++;
        if (k == 15) s = 1'b1;
      end
    end
    check(n == 1 && s, "R10 one sample at expiry", n, 1);

    enable_i = 1'b0;
    step();
    finish_run();
  end
endmodule